// File: doc/BRIEF.md
# Instruction Prefetch Address Issuer

The block drives the address side of a processor's memory port. Left alone, it walks a program counter forward one word at a time and issues each value as an instruction fetch. An execution stage can offer two other kinds of address through a single request channel. A branch target is sent to memory in the next free slot and redirects the counter, so fetching carries on from there. A data-transfer address takes one memory slot and leaves the counter untouched, so fetching resumes at the word that would have been issued next.

Every instruction fetch address, whether sequential or a branch target, is written into a small PC queue. When an instruction reaches decode, that stage pops the oldest entry to learn the instruction's own address. It also receives the value a read of the program-counter register must return, which is that address plus 8. Each taken branch flips a one-bit colour. Every fetch and every queue entry carries the colour that was current when it was issued, so decode can drop stale instructions and addresses left over from before the branch. The instruction queue itself is outside this block, but its depth is a parameter. Elaboration stops with an error unless that depth is at least three more than the PC queue depth, because a smaller margin can deadlock the pipeline.

The issuer is a four-state machine:
- `ST_IDLE`: no request is outstanding.
- `ST_SEQ`: a sequential fetch is outstanding.
- `ST_BRA`: a branch-target fetch is outstanding.
- `ST_DAT`: a data access is outstanding.

A new request can be loaded when the machine is idle, or in the same cycle that memory accepts the outstanding request. At that point the machine picks, in this order:
- `SEL_BRANCH`: the offered request is a branch and the PC queue has room.
- `SEL_DATA`: the offered request is a data access.
- `SEL_SEQ`: nothing is offered and the PC queue has room.
- `SEL_NONE`: anything else.

With `SEL_NONE`, the machine goes back to `ST_IDLE` if it was free to load, and otherwise stays where it is.

Top module: `ifetch_addr_unit`

## Requirements
- R1: During reset `mreq_valid`, `pcq_valid` and `cur_color` are 0. The first request after reset is a sequential fetch of `RESET_VEC`.
- R2: With nothing offered, accepted sequential fetches (`mreq_kind` 2'b00) have addresses that rise by 4, one after another.
- R3: An accepted branch (`ex_is_branch`=1) is issued in the next cycle with `mreq_kind` 2'b01 at the target address. Sequential fetching then continues from target+4.
- R4: `cur_color` toggles on every accepted branch and is unchanged otherwise. Each fetch request and each PC-queue entry carries the colour in force when it was issued; a branch-target fetch carries the new colour.
- R5: An accepted data request (`ex_is_branch`=0) gives exactly one request with `mreq_kind` 2'b10 at its address. It adds no PC-queue entry, and the next sequential fetch is the one that would have followed anyway.
- R6: When a slot opens and an execution request can be taken, it is issued ahead of any sequential fetch.
- R7: While `mreq_valid` is 1 and `mreq_ready` is 0, the request (address, kind, colour) is held unchanged into the next cycle.
- R8: The PC queue returns fetch addresses (sequential and branch) in issue order with their colours, and `pcq_r15` equals `pcq_pc`+8.
- R9: While the PC queue holds `PCQ_DEPTH` entries, no fetch is issued and a branch is not accepted. A data request is still accepted.
- R10: `ex_ready` is 0 whenever an outstanding memory request is being stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ex_valid | input | 1 | Execution stage offers an address |
| ex_ready | output | 1 | Offered address is taken this cycle |
| ex_is_branch | input | 1 | 1 = branch target, 0 = data transfer address |
| ex_addr | input | ADDR_W | Offered address |
| mreq_valid | output | 1 | Memory request present |
| mreq_ready | input | 1 | Memory takes the request |
| mreq_addr | output | ADDR_W | Request address |
| mreq_kind | output | 2 | 00 sequential fetch, 01 branch-target fetch, 10 data |
| mreq_color | output | 1 | Flush colour of the request |
| pcq_valid | output | 1 | PC queue holds an entry |
| pcq_ready | input | 1 | Decode pops the oldest entry |
| pcq_pc | output | ADDR_W | Address of the oldest entry |
| pcq_r15 | output | ADDR_W | Oldest entry plus 8 |
| pcq_color | output | 1 | Colour of the oldest entry |
| cur_color | output | 1 | Current flush colour |

## Verification
Three events can land on the same clock edge. Memory accepting the outstanding request frees the slot. A branch or data request is taken into that slot. Decode pops an entry from the PC queue. The bench brings these together by offering execution requests while it randomly toggles memory readiness and queue popping. It also fills the queue completely and then offers a branch and a data request against it. The scoreboard applies a memory acceptance to its model before the execution handshake from the same cycle, and logs a new queue entry before a pop from that cycle. A wrong order in the design therefore shows up as an address, kind or colour mismatch.

// File: rtl/ifu_pkg.sv
`timescale 1ns/1ps
package ifu_pkg;

    // Memory request kinds carried on mreq_kind
    typedef enum logic [1:0] {
        REQ_SEQ    = 2'b00,
        REQ_BRANCH = 2'b01,
        REQ_DATA   = 2'b10
    } req_kind_e;

    // Outstanding-request state of the issuer
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEQ,
        ST_BRA,
        ST_DAT
    } issue_state_e;

    // Source chosen for the next slot
    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_BRANCH,
        SEL_DATA,
        SEL_SEQ
    } slot_sel_e;

endpackage

// File: rtl/ifu_pcq.sv
`timescale 1ns/1ps
module ifu_pcq #(
    parameter int DW    = 33,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          valid,
    output logic          full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);

    logic [DW-1:0] slot_q [DEPTH];
    logic [PW-1:0] wr_ptr_q, rd_ptr_q;
    logic [CW-1:0] count_q;
    logic          do_push, do_pop;

    assign full    = (count_q == CAP);
    assign valid   = (count_q != '0);
    assign do_push = push && !full;
    assign do_pop  = pop && valid;
    assign head    = slot_q[rd_ptr_q];

    // One register per entry, written when the write pointer selects it
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (do_push && (wr_ptr_q == PW'(i))) begin
                slot_q[i] <= push_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
            end
            if (do_pop) begin
                rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
            end
            count_q <= count_q + CW'(do_push) - CW'(do_pop);
        end
    end

endmodule

// File: rtl/ifu_issue.sv
`timescale 1ns/1ps
module ifu_issue
    import ifu_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] RESET_VEC = '0,
    parameter int                STEP      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ex_valid,
    input  logic              ex_is_branch,
    input  logic [ADDR_W-1:0] ex_addr,
    output logic              ex_ready,
    input  logic              mreq_ready,
    output logic              mreq_valid,
    output logic [ADDR_W-1:0] mreq_addr,
    output req_kind_e         mreq_kind,
    output logic              mreq_color,
    input  logic              pcq_full,
    output logic              pcq_push,
    output logic [ADDR_W-1:0] pcq_push_pc,
    output logic              pcq_push_color,
    output logic              cur_color
);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    issue_state_e      state_q, state_d;
    slot_sel_e         sel;
    logic [ADDR_W-1:0] pc_q, addr_q;
    logic              color_q, req_color_q;
    logic              can_load;

    // A slot is free when idle or when memory takes the outstanding request
    assign can_load = (state_q == ST_IDLE) || mreq_ready;

    // Slot selection: branch, then data, then sequential prefetch
    always_comb begin
        sel = SEL_NONE;
        if (can_load) begin
            if (ex_valid) begin
                if (ex_is_branch) begin
                    if (!pcq_full) sel = SEL_BRANCH;
                end else begin
                    sel = SEL_DATA;
                end
            end else if (!pcq_full) begin
                sel = SEL_SEQ;
            end
        end
    end

    always_comb begin
        unique case (sel)
            SEL_BRANCH: state_d = ST_BRA;
            SEL_DATA:   state_d = ST_DAT;
            SEL_SEQ:    state_d = ST_SEQ;
            default:    state_d = can_load ? ST_IDLE : state_q;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs decoded from the state
    always_comb begin
        unique case (state_q)
            ST_IDLE: begin mreq_valid = 1'b0; mreq_kind = REQ_SEQ;    end
            ST_SEQ:  begin mreq_valid = 1'b1; mreq_kind = REQ_SEQ;    end
            ST_BRA:  begin mreq_valid = 1'b1; mreq_kind = REQ_BRANCH; end
            ST_DAT:  begin mreq_valid = 1'b1; mreq_kind = REQ_DATA;   end
            default: begin mreq_valid = 1'b0; mreq_kind = REQ_SEQ;    end
        endcase
    end

    // Request address, program counter and flush colour
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q        <= RESET_VEC;
            addr_q      <= RESET_VEC;
            color_q     <= 1'b0;
            req_color_q <= 1'b0;
        end else begin
            unique case (sel)
                SEL_BRANCH: begin
                    addr_q      <= ex_addr;
                    pc_q        <= ex_addr + STEP_V;
                    color_q     <= ~color_q;
                    req_color_q <= ~color_q;
                end
                SEL_DATA: begin
                    addr_q      <= ex_addr;
                    req_color_q <= color_q;
                end
                SEL_SEQ: begin
                    addr_q      <= pc_q;
                    pc_q        <= pc_q + STEP_V;
                    req_color_q <= color_q;
                end
                default: ;
            endcase
        end
    end

    assign ex_ready       = (sel == SEL_BRANCH) || (sel == SEL_DATA);
    assign mreq_addr      = addr_q;
    assign mreq_color     = req_color_q;
    assign cur_color      = color_q;
    assign pcq_push       = (sel == SEL_BRANCH) || (sel == SEL_SEQ);
    assign pcq_push_pc    = (sel == SEL_BRANCH) ? ex_addr : pc_q;
    assign pcq_push_color = (sel == SEL_BRANCH) ? ~color_q : color_q;

endmodule

// File: rtl/ifetch_addr_unit.sv
`timescale 1ns/1ps
module ifetch_addr_unit
    import ifu_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] RESET_VEC = 32'h0000_0100,
    parameter int                PCQ_DEPTH = 4,
    parameter int                IQ_DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ex_valid,
    output logic              ex_ready,
    input  logic              ex_is_branch,
    input  logic [ADDR_W-1:0] ex_addr,
    output logic              mreq_valid,
    input  logic              mreq_ready,
    output logic [ADDR_W-1:0] mreq_addr,
    output logic [1:0]        mreq_kind,
    output logic              mreq_color,
    output logic              pcq_valid,
    input  logic              pcq_ready,
    output logic [ADDR_W-1:0] pcq_pc,
    output logic [ADDR_W-1:0] pcq_r15,
    output logic              pcq_color,
    output logic              cur_color
);
    localparam int                FETCH_BYTES = 4;
    localparam logic [ADDR_W-1:0] R15_OFS     = ADDR_W'(2 * FETCH_BYTES);
    localparam int                ENTRY_W     = ADDR_W + 1;

    if (IQ_DEPTH < PCQ_DEPTH + 3) begin : g_depth_bad
        $error("instruction queue depth must exceed PC queue depth by at least 3");
    end

    req_kind_e         kind;
    logic              pcq_full;
    logic              push, push_color;
    logic [ADDR_W-1:0] push_pc;
    logic [ENTRY_W-1:0] head;

    ifu_issue #(
        .ADDR_W   (ADDR_W),
        .RESET_VEC(RESET_VEC),
        .STEP     (FETCH_BYTES)
    ) u_issue (
        .clk           (clk),
        .rst_n         (rst_n),
        .ex_valid      (ex_valid),
        .ex_is_branch  (ex_is_branch),
        .ex_addr       (ex_addr),
        .ex_ready      (ex_ready),
        .mreq_ready    (mreq_ready),
        .mreq_valid    (mreq_valid),
        .mreq_addr     (mreq_addr),
        .mreq_kind     (kind),
        .mreq_color    (mreq_color),
        .pcq_full      (pcq_full),
        .pcq_push      (push),
        .pcq_push_pc   (push_pc),
        .pcq_push_color(push_color),
        .cur_color     (cur_color)
    );

    ifu_pcq #(
        .DW   (ENTRY_W),
        .DEPTH(PCQ_DEPTH)
    ) u_pcq (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_data({push_color, push_pc}),
        .pop      (pcq_ready),
        .head     (head),
        .valid    (pcq_valid),
        .full     (pcq_full)
    );

    assign mreq_kind = kind;
    assign pcq_pc    = head[ADDR_W-1:0];
    assign pcq_color = head[ADDR_W];
    assign pcq_r15   = head[ADDR_W-1:0] + R15_OFS;

endmodule

// File: rtl/ifetch_addr_unit_chk.sv
`timescale 1ns/1ps
module ifetch_addr_unit_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ex_valid,
    input logic              ex_ready,
    input logic              ex_is_branch,
    input logic [ADDR_W-1:0] ex_addr,
    input logic              mreq_valid,
    input logic              mreq_ready,
    input logic [ADDR_W-1:0] mreq_addr,
    input logic [1:0]        mreq_kind,
    input logic              mreq_color,
    input logic              cur_color,
    input logic              pcq_full
);
    a_r3_branch_issued: assert property (@(posedge clk) disable iff (!rst_n)
        ex_valid && ex_ready && ex_is_branch |=>
            mreq_valid && mreq_kind == 2'b01 && mreq_addr == $past(ex_addr));

    a_r4_color_flips: assert property (@(posedge clk) disable iff (!rst_n)
        ex_valid && ex_ready && ex_is_branch |=> cur_color != $past(cur_color));

    a_r5_data_keeps_color: assert property (@(posedge clk) disable iff (!rst_n)
        ex_valid && ex_ready && !ex_is_branch |=>
            $stable(cur_color) && mreq_kind == 2'b10);

    a_r7_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_valid && !mreq_ready |=>
            mreq_valid && $stable(mreq_addr) && $stable(mreq_kind) && $stable(mreq_color));

    a_r9_full_blocks_branch: assert property (@(posedge clk) disable iff (!rst_n)
        pcq_full && ex_valid && ex_is_branch |-> !ex_ready);

    a_r10_no_take_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_valid && !mreq_ready |-> !ex_ready);

endmodule

bind ifetch_addr_unit ifetch_addr_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ex_valid    (ex_valid),
    .ex_ready    (ex_ready),
    .ex_is_branch(ex_is_branch),
    .ex_addr     (ex_addr),
    .mreq_valid  (mreq_valid),
    .mreq_ready  (mreq_ready),
    .mreq_addr   (mreq_addr),
    .mreq_kind   (mreq_kind),
    .mreq_color  (mreq_color),
    .cur_color   (cur_color),
    .pcq_full    (pcq_full)
);

// File: tb/ifetch_addr_unit_test.sv
`timescale 1ns/1ps
module ifetch_addr_unit_test;
    localparam logic [31:0] VEC = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ex_valid = 1'b0, ex_is_branch = 1'b0;
    logic [31:0] ex_addr = '0;
    logic        ex_ready;
    logic        mreq_valid, mreq_color;
    logic        mreq_ready = 1'b1;
    logic [31:0] mreq_addr;
    logic [1:0]  mreq_kind;
    logic        pcq_valid, pcq_color, cur_color;
    logic        pcq_ready = 1'b1;
    logic [31:0] pcq_pc, pcq_r15;

    int vectors = 0;
    int fails   = 0;

    always #2.5 clk = ~clk;

    ifetch_addr_unit #(.ADDR_W(32), .RESET_VEC(VEC), .PCQ_DEPTH(4), .IQ_DEPTH(7)) uut (
        .clk(clk), .rst_n(rst_n),
        .ex_valid(ex_valid), .ex_ready(ex_ready), .ex_is_branch(ex_is_branch), .ex_addr(ex_addr),
        .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_addr(mreq_addr),
        .mreq_kind(mreq_kind), .mreq_color(mreq_color),
        .pcq_valid(pcq_valid), .pcq_ready(pcq_ready), .pcq_pc(pcq_pc), .pcq_r15(pcq_r15),
        .pcq_color(pcq_color), .cur_color(cur_color)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Scoreboard state
    logic [33:0] exp_q[$];     // {kind, addr} of execution-originated requests
    logic [32:0] pc_exp_q[$];  // {color, pc} of fetch entries expected in the PC queue
    logic [31:0] model_pc  = VEC;
    logic        model_col = 1'b0;
    bit          first_req = 1'b1;
    bit          ex_next   = 1'b0;
    bit          prev_stall = 1'b0;
    logic [31:0] prev_addr;
    logic [1:0]  prev_kind;
    logic        prev_color;

    // Driver: offers one execution request and queues what memory must see
    task automatic send_ex(input logic br, input logic [31:0] a);
        @(posedge clk); #1;
        ex_valid = 1'b1; ex_is_branch = br; ex_addr = a;
        do @(negedge clk); while (!ex_ready);
        exp_q.push_back({br ? 2'b01 : 2'b10, a});
        @(posedge clk); #1;
        ex_valid = 1'b0;
    endtask

    // Monitor
    always @(negedge clk) begin
        if (rst_n) begin
            check(cur_color == model_col, "R4 cur_color", 64'(cur_color), 64'(model_col));
            if (prev_stall) begin
                check(mreq_valid && mreq_addr == prev_addr && mreq_kind == prev_kind &&
                      mreq_color == prev_color, "R7 held request",
                      {mreq_kind, mreq_addr}, {prev_kind, prev_addr});
            end
            if (mreq_valid && !mreq_ready)
                check(!ex_ready, "R10 ex_ready in stall", 64'(ex_ready), 64'd0);
            // new request presented: fetches must appear in the PC queue
            if (mreq_valid && !prev_stall && mreq_kind != 2'b10)
                pc_exp_q.push_back({mreq_color, mreq_addr});
            // memory acceptance
            if (mreq_valid && mreq_ready) begin
                if (mreq_kind == 2'b00) begin
                    check(!ex_next, "R6 exec request first", 64'(mreq_kind), 64'd1);
                    check(mreq_addr == model_pc && mreq_color == model_col,
                          first_req ? "R1 first fetch" : "R2 sequential fetch",
                          {mreq_color, mreq_addr}, {model_col, model_pc});
                    model_pc = model_pc + 32'd4;
                end else if (exp_q.size() == 0) begin
                    check(1'b0, "R6 unexpected request", {mreq_kind, mreq_addr}, 64'd0);
                end else begin
                    logic [33:0] e;
                    e = exp_q.pop_front();
                    check({mreq_kind, mreq_addr} == e,
                          e[33:32] == 2'b01 ? "R3 branch request" : "R5 data request",
                          {mreq_kind, mreq_addr}, e);
                    if (mreq_kind == 2'b01)
                        check(mreq_color == model_col, "R4 branch colour",
                              64'(mreq_color), 64'(model_col));
                    ex_next = 1'b0;
                end
                first_req = 1'b0;
            end
            // decode pop
            if (pcq_valid && pcq_ready) begin
                if (pc_exp_q.size() == 0) begin
                    check(1'b0, "R8 extra PC entry", {pcq_color, pcq_pc}, 64'd0);
                end else begin
                    logic [32:0] p;
                    p = pc_exp_q.pop_front();
                    check({pcq_color, pcq_pc} == p, "R8 PC queue order", {pcq_color, pcq_pc}, p);
                    check(pcq_r15 == p[31:0] + 32'd8, "R8 r15 value", pcq_r15, p[31:0] + 32'd8);
                end
            end
            // execution handshake updates the model
            if (ex_valid && ex_ready) begin
                ex_next = 1'b1;
                if (ex_is_branch) begin
                    model_pc  = ex_addr + 32'd4;
                    model_col = ~model_col;
                end
            end
            prev_stall = mreq_valid && !mreq_ready;
            prev_addr  = mreq_addr;
            prev_kind  = mreq_kind;
            prev_color = mreq_color;
        end
    end

    bit rnd_en = 1'b0;
    always @(posedge clk) begin
        if (rnd_en) begin
            #1;
            mreq_ready = ($urandom_range(0, 3) != 0);
            pcq_ready  = ($urandom_range(0, 2) != 0);
        end
    end

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired (all requirements)");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(mreq_valid == 1'b0, "R1 reset mreq_valid", 64'(mreq_valid), 64'd0);
        check(pcq_valid == 1'b0, "R1 reset pcq_valid", 64'(pcq_valid), 64'd0);
        check(cur_color == 1'b0, "R1 reset colour", 64'(cur_color), 64'd0);
        rst_n = 1'b1;
        repeat (12) @(posedge clk);

        // R5: data request interrupts prefetch for one slot
        send_ex(1'b0, 32'h8000_0040);
        repeat (6) @(posedge clk);

        // R3/R4: two branches, colour goes 1 then 0
        send_ex(1'b1, 32'h0000_2000);
        repeat (6) @(posedge clk);
        send_ex(1'b1, 32'h0000_3000);
        repeat (6) @(posedge clk);

        // R7/R10: memory stall while a data request waits
        #1 mreq_ready = 1'b0;
        fork
            send_ex(1'b0, 32'h8000_0100);
            begin repeat (5) @(posedge clk); #1 mreq_ready = 1'b1; end
        join
        repeat (4) @(posedge clk);

        // R9: PC queue full
        #1 pcq_ready = 1'b0;
        repeat (12) @(posedge clk);
        @(negedge clk);
        check(mreq_valid == 1'b0, "R9 no fetch while full", 64'(mreq_valid), 64'd0);
        send_ex(1'b0, 32'h8000_0200);   // data still accepted
        fork
            send_ex(1'b1, 32'h0000_4000);
            begin
                repeat (6) @(negedge clk);
                check(ex_ready == 1'b0, "R9 branch held while full", 64'(ex_ready), 64'd0);
                @(posedge clk); #1 pcq_ready = 1'b1;
            end
        join
        repeat (6) @(posedge clk);

        // Mixed traffic with random stalls and pops
        rnd_en = 1'b1;
        for (int i = 0; i < 30; i++) begin
            send_ex(i[0], (i[0] ? 32'h0001_0000 : 32'h9000_0000) + 32'(i * 64));
            repeat ($urandom_range(1, 8)) @(posedge clk);
        end
        rnd_en = 1'b0;
        @(posedge clk); #1 mreq_ready = 1'b1; pcq_ready = 1'b1;
        repeat (20) @(posedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, "R6 all exec requests issued", 64'(exp_q.size()), 64'd0);
        summary();
    end

endmodule